// File: doc/BRIEF.md
# Chainable Input Serializer with Status Word

This block is the digital half of an eight-input serializer that sits on a serial peripheral bus as a slave. When the chip-select line goes low, it takes a snapshot of its parallel inputs and of three alarm conditions. It then shifts that snapshot out on the serial data line, one bit per rising serial-clock edge, most significant bit first.

A frame-length pin picks the frame format. A short frame carries only the input byte. A long frame carries the input byte followed by a status byte. The status byte holds a 5-bit CRC of the input byte, an over-temperature flag, and two active-low supply alarm bits. A serial-in pin feeds the tail of the shift path. Because of this, any number of instances can share chip-select and clock while their data lines are cascaded: the bits of the next device downstream follow this device's own frame. The block samples all bus pins on its system clock, and the bus pins are treated as synchronous to that clock.

Top module: `chain_input_serializer`

## Requirements
- R1: After synchronous reset, `sdo` is 0.
- R2: The clock edge that samples `cs_n` high drives `sdo` to 0, and `sdo` stays 0 while `cs_n` stays high, whatever `sclk` does.
- R3: The clock edge that first samples `cs_n` low captures `din`, the alarm inputs and `short_frame`. From the next cycle, `sdo` shows `din[7]`. Each later rising `sclk` edge advances one bit, giving `din[7]` down to `din[0]`. Changes on `din` after capture do not affect the frame, and `sdo` holds still between `sclk` rising edges.
- R4: In a long frame (`short_frame`=0 at capture), bits 8 to 15 of the frame are the status byte, sent from status bit 7 down to bit 0. Status bits 7..3 are the CRC-5 of the captured input byte: polynomial x^5+x^4+x^2+1, input taken MSB first, register starting at zero, register MSB in status bit 7.
- R5: Status bit 1 equals the captured `ot_flag` (1 = over-temperature).
- R6: Status bit 2 is the inverse of the captured `uv_alarm`, and status bit 0 is the inverse of the captured `uv_warn`. Both are 0 when the condition is present.
- R7: In a short frame, the bit on `sdi` at the k-th rising `sclk` edge (k from 1) appears on `sdo` as frame bit 7+k, that is, after the 8 own bits.
- R8: In a long frame, the bit on `sdi` at the k-th rising `sclk` edge appears on `sdo` as frame bit 15+k, that is, after the 16 own bits.
- R9: The frame length is fixed at capture. A change on `short_frame` during the frame has no effect on the bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; falling edge captures |
| sclk | input | 1 | Serial clock; rising edge shifts |
| sdi | input | 1 | Serial input from the downstream device |
| short_frame | input | 1 | 1 = input byte only, 0 = input byte plus status byte |
| din | input | DATA_W | Parallel input bits |
| ot_flag | input | 1 | Over-temperature condition, active high |
| uv_alarm | input | 1 | Supply under-voltage alarm condition, active high |
| uv_warn | input | 1 | Supply under-voltage warning condition, active high |
| sdo | output | 1 | Serial data out, MSB first |

## Verification
Every internal fault surfaces at `sdo` as a wrong bit at a known frame position. A wrong capture shows in the first bit, one cycle after select. A wrong CRC or alarm mapping shows at frame bits 8 to 15 of a long frame. A wrong insertion point for `sdi` shows at the first bit after the own frame. Each frame is also read 8 bits past its end with a known chained pattern. Alongside it, the input byte and the frame-length pin are changed mid-frame. Together these expose a shift that went off by one, a length that was not latched, and data that was not held.

// File: rtl/ser_pkg.sv
package ser_pkg;
  parameter int unsigned SER_DATA_W = 8;
  localparam int unsigned SER_CRC_W = SER_DATA_W - 3;
  localparam logic [SER_CRC_W-1:0] SER_CRC_POLY = 5'h15;

  // Bitwise CRC, input MSB first, register cleared at start.
  function automatic logic [SER_CRC_W-1:0] crc_calc(input logic [SER_DATA_W-1:0] d);
    logic [SER_CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = SER_DATA_W - 1; i >= 0; i--) begin
      fb = c[SER_CRC_W-1] ^ d[i];
      c  = {c[SER_CRC_W-2:0], 1'b0} ^ (fb ? SER_CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/ser_edge_detect.sv
module ser_edge_detect (
  input  logic clk,
  input  logic cs_n,
  input  logic sclk,
  output logic frame_start,
  output logic shift_pulse,
  output logic deselected
);
  logic cs_q;
  logic sclk_q;

  // History registers track the pins every cycle; no reset needed.
  always_ff @(posedge clk) begin
    cs_q   <= cs_n;
    sclk_q <= sclk;
  end

  assign frame_start = cs_q & ~cs_n;
  assign shift_pulse = ~sclk_q & sclk & ~cs_n;
  assign deselected  = cs_n;
endmodule

// File: rtl/ser_status_build.sv
module ser_status_build
  import ser_pkg::*;
#(
  parameter int unsigned DATA_W = SER_DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic              ot_flag,
  input  logic              uv_alarm,
  input  logic              uv_warn,
  output logic [DATA_W-1:0] status
);
  always_comb begin
    status[DATA_W-1:3] = crc_calc(din);
    status[2]          = ~uv_alarm;
    status[1]          = ot_flag;
    status[0]          = ~uv_warn;
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned FW = 2 * DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic          idle,
  input  logic          short_in,
  input  logic [FW-1:0] frame_in,
  input  logic          sdi,
  output logic          sdo
);
  logic [FW-1:0] sr;
  logic          short_q;
  logic [FW-1:0] nxt;

  // Short frames take the chained bit in just below the input byte.
  always_comb begin
    if (short_q) nxt = {sr[FW-2:DATA_W], sdi, {DATA_W{1'b0}}};
    else         nxt = {sr[FW-2:0], sdi};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      short_q <= 1'b0;
    end else if (idle) begin
      sr <= '0;
    end else if (load) begin
      sr      <= frame_in;
      short_q <= short_in;
    end else if (shift) begin
      sr <= nxt;
    end
  end

  assign sdo = sr[FW-1];
endmodule

// File: rtl/chain_input_serializer.sv
module chain_input_serializer
  import ser_pkg::*;
#(
  parameter int unsigned DATA_W = SER_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              short_frame,
  input  logic [DATA_W-1:0] din,
  input  logic              ot_flag,
  input  logic              uv_alarm,
  input  logic              uv_warn,
  output logic              sdo
);
  localparam int unsigned FW = 2 * DATA_W;

  logic              frame_start;
  logic              shift_pulse;
  logic              deselected;
  logic [DATA_W-1:0] status;

  ser_edge_detect u_edge (
    .clk         (clk),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .frame_start (frame_start),
    .shift_pulse (shift_pulse),
    .deselected  (deselected)
  );

  ser_status_build #(.DATA_W(DATA_W)) u_status (
    .din      (din),
    .ot_flag  (ot_flag),
    .uv_alarm (uv_alarm),
    .uv_warn  (uv_warn),
    .status   (status)
  );

  ser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (frame_start),
    .shift    (shift_pulse),
    .idle     (deselected),
    .short_in (short_frame),
    .frame_in ({din, status}),
    .sdi      (sdi),
    .sdo      (sdo)
  );
endmodule

// File: rtl/chain_input_serializer_chk.sv
module chain_input_serializer_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic din_msb,
  input logic sdo
);
  // R1
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !sdo);

  // R2
  a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !sdo);

  // R3
  a_r3_first_bit: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(cs_n)) |=> (sdo == $past(din_msb)));

  // R3
  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && !(sclk && !$past(sclk))) |=> $stable(sdo));
endmodule

bind chain_input_serializer chain_input_serializer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .din_msb (din[DATA_W-1]),
  .sdo     (sdo)
);

// File: tb/chain_input_serializer_bench.sv
module chain_input_serializer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       short_frame = 1'b0;
  logic [7:0] din = 8'h00;
  logic       ot_flag = 1'b0;
  logic       uv_alarm = 1'b0;
  logic       uv_warn = 1'b0;
  logic       sdo;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chain_input_serializer u_chain_input_serializer (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .short_frame(short_frame), .din(din), .ot_flag(ot_flag),
    .uv_alarm(uv_alarm), .uv_warn(uv_warn), .sdo(sdo)
  );

  // Byte-wide CRC form: poly 0xA8 = x^5+x^4+x^2+1 left-aligned.
  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [7:0] c;
    c = d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'hA8) : (c << 1);
    return c[7:3];
  endfunction

  function automatic logic [7:0] ref_status(input logic [7:0] d, input logic ot,
                                            input logic uva, input logic uvw);
    return {ref_crc(d), !uva, ot, !uvw};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input logic sf, input logic ot,
                           input logic uva, input logic uvw, input logic [7:0] chain);
    logic [7:0] st;
    int own;
    logic e;
    string tag;
    st  = ref_status(d, ot, uva, uvw);
    own = sf ? 8 : 16;
    @(negedge clk);
    din = d; short_frame = sf; ot_flag = ot; uv_alarm = uva; uv_warn = uvw; sdi = 1'b0;
    cs_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < own + 8; i++) begin
      if (i < 8) begin
        e = d[7-i]; tag = "R3";
      end else if (i < own) begin
        e = st[15-i];
        if (i < 13) tag = "R4";
        else if (i == 14) tag = "R5";
        else tag = "R6";
      end else begin
        e = chain[7-(i-own)];
        tag = sf ? "R7 R9" : "R8 R9";
      end
      check(tag, sdo, e);
      sdi = chain[7-i%8];
      if (i == 3) begin
        din = ~d; short_frame = ~sf; ot_flag = ~ot; uv_alarm = ~uva;  // R3 R9: ignored
      end
      sclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2", sdo, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    check("R1", sdo, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", sdo, 1'b0);
    // R2: clocking while deselected keeps the line low
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; @(negedge clk); @(negedge clk);
      check("R2", sdo, 1'b0);
      sclk = 1'b0; @(negedge clk);
    end
    // Directed corners
    run_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    run_frame(8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C);
    run_frame(8'h80, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01);
    run_frame(8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF);
    run_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3);
    run_frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    // Random frames
    for (int n = 0; n < 40; n++) begin
      run_frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule